// File: doc/BRIEF.md
# Link BIST PRBS Checker

This block sits at the receive end of a high-speed serial link during an at-speed self test. Each cycle of the recovered pixel clock it takes one recovered parallel word and compares it with a locally generated PRBS-7 stream. It reports every mismatching bit on a single pass/fail pin as a short low pulse, so an external counter can tally bit errors without reading any register. It also keeps a saturating error total that stays readable for the whole run.

A run lasts exactly as long as the test-enable input stays high. The checker seeds its generator from the first locked word of the run and then runs freely. A drop of the lock input pauses checking, and the next locked word re-seeds the generator. When the enable input falls, the pin first finishes any queued error pulses. It then holds the verdict of the run until the next run starts, and words that arrive in that time change nothing.

Top module: `link_bist_checker`

## Requirements
- R1: After reset `pass_o` is high and `err_count` is 0. While `bist_en` is low, no received word changes `err_count`.
- R2: The first word sampled with `bist_en` and `lock` both high after a run starts (the rising edge of `bist_en`, or a lock return) is never counted. Its bits 15..9 seed the generator. Each later word k carries sequence bits s[16k+i] in bit i, where s[n] = s[n-6] XOR s[n-7] (polynomial x^7 + x^6 + 1) and the seed word is word 0.
- R3: During a run, while no error pulse is pending, `pass_o` stays high through both clock phases.
- R4: Each mismatching bit produces one pulse on `pass_o`: low while `clk` is low, high while `clk` is high. Pulses are emitted one per clock cycle, starting in the cycle that follows the edge that sampled the bad word, so the total pulse count equals the total number of mismatching bits.
- R5: At the edge that samples a checked word, `err_count` increases by the number of bits in which the word differs from the expected word.
- R6: `err_count` saturates at 65535 and never wraps.
- R7: A rising edge of `bist_en` clears `err_count`, the failure verdict and any pending pulses.
- R8: After `bist_en` falls and the pending pulses are drained, `pass_o` holds high if the run saw zero bit errors and low otherwise.
- R9: After a run has ended, received words leave `err_count` and the held verdict unchanged until the next rising edge of `bist_en`.
- R10: While `lock` is low, words are not checked and not counted. When lock returns, the next locked word re-seeds the generator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_en | input | 1 | Test run enable; the run lasts while high |
| lock | input | 1 | Receiver lock indication |
| rx_word | input | 16 | Recovered parallel data word |
| pass_o | output | 1 | Error pulse train during a run, held verdict after it |
| err_count | output | 16 | Saturating accumulated bit-error count |

## Verification
The bench aims at frames with several bad bits. A checker that flagged a word once, instead of once per bit, would produce fewer pulses than the error total. It also tests that the pulse backlog is drained before the verdict appears: an early verdict would cut the pulse train short. Re-seeding after a lock drop is tested with a word taken from an unrelated point in the stream, which a checker that kept its old generator state would count as many errors. The saturation run pushes more than 65535 errors, where a wrapping counter would read a small value.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

    localparam int unsigned DEF_WORD_W   = 16;
    localparam int unsigned DEF_CNT_W    = 16;
    localparam int unsigned DEF_PEND_W   = 20;
    localparam int unsigned DEF_PRBS_ORD = 7;
    localparam int unsigned DEF_TAP_HI   = 7;
    localparam int unsigned DEF_TAP_LO   = 6;

    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_SEED  = 2'd1,
        RUN_CHECK = 2'd2,
        RUN_DONE  = 2'd3
    } run_state_e;

    typedef struct packed {
        logic start;
        logic seed;
        logic check;
    } run_ctl_s;

    function automatic int unsigned pop_width(input int unsigned w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/lbc_popcount.sv
module lbc_popcount #(
    parameter int unsigned W  = 16,
    parameter int unsigned OW = lbc_pkg::pop_width(W)
) (
    input  logic [W-1:0]  bits_i,
    output logic [OW-1:0] count_o
);
    logic [OW-1:0] part [0:W];

    assign part[0] = '0;

    for (genvar g = 0; g < W; g++) begin : g_sum
        assign part[g+1] = part[g] + OW'(bits_i[g]);
    end

    assign count_o = part[W];
endmodule

// File: rtl/lbc_prbs_step.sv
module lbc_prbs_step #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ORD    = 7,
    parameter int unsigned TAP_HI = 7,
    parameter int unsigned TAP_LO = 6
) (
    input  logic [ORD-1:0]    state_i,
    output logic [WORD_W-1:0] word_o,
    output logic [ORD-1:0]    state_o
);
    // state bit 0 holds the oldest sequence bit, bit ORD-1 the newest
    localparam int unsigned IDX_HI = ORD - TAP_HI;
    localparam int unsigned IDX_LO = ORD - TAP_LO;

    logic [ORD-1:0] chain [0:WORD_W];

    assign chain[0] = state_i;

    for (genvar g = 0; g < WORD_W; g++) begin : g_bit
        logic fb;
        assign fb          = chain[g][IDX_HI] ^ chain[g][IDX_LO];
        assign word_o[g]   = fb;
        assign chain[g+1]  = {fb, chain[g][ORD-1:1]};
    end

    assign state_o = chain[WORD_W];
endmodule

// File: rtl/lbc_err_accum.sv
module lbc_err_accum #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned ADD_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic [ADD_W-1:0] add_i,
    output logic [CNT_W-1:0] count_o,
    output logic             fail_o
);
    localparam int unsigned SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] sum_w;
    logic [CNT_W-1:0] next_w;

    assign sum_w  = {1'b0, count_o} + SUM_W'(add_i);
    assign next_w = sum_w[CNT_W] ? {CNT_W{1'b1}} : sum_w[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            count_o <= '0;
            fail_o  <= 1'b0;
        end else begin
            count_o <= next_w;
            if (add_i != '0) begin
                fail_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lbc_pulse_queue.sv
module lbc_pulse_queue #(
    parameter int unsigned PEND_W = 20,
    parameter int unsigned ADD_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic [ADD_W-1:0]  add_i,
    output logic              busy_o,
    output logic [PEND_W-1:0] pending_o
);
    localparam int unsigned SUM_W = PEND_W + 1;

    logic [SUM_W-1:0] sum_w;

    assign busy_o = (pending_o != '0);
    assign sum_w  = {1'b0, pending_o} - SUM_W'(busy_o) + SUM_W'(add_i);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            pending_o <= '0;
        end else if (sum_w[PEND_W]) begin
            pending_o <= {PEND_W{1'b1}};
        end else begin
            pending_o <= sum_w[PEND_W-1:0];
        end
    end
endmodule

// File: rtl/link_bist_checker.sv
module link_bist_checker #(
    parameter int unsigned WORD_W   = lbc_pkg::DEF_WORD_W,
    parameter int unsigned CNT_W    = lbc_pkg::DEF_CNT_W,
    parameter int unsigned PEND_W   = lbc_pkg::DEF_PEND_W,
    parameter int unsigned PRBS_ORD = lbc_pkg::DEF_PRBS_ORD,
    parameter int unsigned TAP_HI   = lbc_pkg::DEF_TAP_HI,
    parameter int unsigned TAP_LO   = lbc_pkg::DEF_TAP_LO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bist_en,
    input  logic              lock,
    input  logic [WORD_W-1:0] rx_word,
    output logic              pass_o,
    output logic [CNT_W-1:0]  err_count
);
    import lbc_pkg::*;

    localparam int unsigned POP_W = pop_width(WORD_W);

    run_state_e          state_q, state_d;
    run_ctl_s            ctl;
    logic                en_q;
    logic                start_w;
    logic [PRBS_ORD-1:0] gen_q, gen_d, gen_adv;
    logic [WORD_W-1:0]   exp_word;
    logic [WORD_W-1:0]   diff_w;
    logic [POP_W-1:0]    nerr_w;
    logic                fail_w;
    logic                busy_w;
    logic [PEND_W-1:0]   pending_w;

    // run control
    assign start_w = bist_en & ~en_q;

    always_comb begin
        ctl.start = start_w;
        ctl.seed  = bist_en & lock & (start_w | (state_q == RUN_SEED));
        ctl.check = bist_en & lock & ~start_w & (state_q == RUN_CHECK);
    end

    always_comb begin
        state_d = state_q;
        if (!bist_en) begin
            if (state_q == RUN_SEED || state_q == RUN_CHECK) begin
                state_d = RUN_DONE;
            end
        end else if (ctl.start) begin
            state_d = lock ? RUN_CHECK : RUN_SEED;
        end else begin
            unique case (state_q)
                RUN_SEED:  state_d = lock ? RUN_CHECK : RUN_SEED;
                RUN_CHECK: state_d = lock ? RUN_CHECK : RUN_SEED;
                default:   state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RUN_IDLE;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= bist_en;
        end
    end

    // expected-pattern generator
    lbc_prbs_step #(
        .WORD_W (WORD_W),
        .ORD    (PRBS_ORD),
        .TAP_HI (TAP_HI),
        .TAP_LO (TAP_LO)
    ) u_gen (
        .state_i (gen_q),
        .word_o  (exp_word),
        .state_o (gen_adv)
    );

    always_comb begin
        gen_d = gen_q;
        if (ctl.seed) begin
            gen_d = rx_word[WORD_W-1 -: PRBS_ORD];
        end else if (ctl.check) begin
            gen_d = gen_adv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    // compare and count the bad bits of this word
    assign diff_w = ctl.check ? (rx_word ^ exp_word) : '0;

    lbc_popcount #(
        .W  (WORD_W),
        .OW (POP_W)
    ) u_pop (
        .bits_i  (diff_w),
        .count_o (nerr_w)
    );

    lbc_err_accum #(
        .CNT_W (CNT_W),
        .ADD_W (POP_W)
    ) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clear_i (ctl.start),
        .add_i   (nerr_w),
        .count_o (err_count),
        .fail_o  (fail_w)
    );

    lbc_pulse_queue #(
        .PEND_W (PEND_W),
        .ADD_W  (POP_W)
    ) u_pq (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (ctl.start),
        .add_i     (nerr_w),
        .busy_o    (busy_w),
        .pending_o (pending_w)
    );

    // pulse output: follows the clock while a pulse is due, otherwise a level
    logic static_lvl;
    assign static_lvl = (state_q == RUN_DONE) ? ~fail_w : 1'b1;
    assign pass_o     = busy_w ? clk : static_lvl;

endmodule

// File: rtl/lbc_sva.sv
module lbc_sva #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned PEND_W = 20,
    parameter int unsigned POP_W  = 5
) (
    input logic                clk,
    input logic                rst,
    input logic                bist_en,
    input logic                lock,
    input logic                start,
    input lbc_pkg::run_state_e state,
    input logic [CNT_W-1:0]    err_count,
    input logic                fail,
    input logic                busy,
    input logic [PEND_W-1:0]   pending,
    input logic [POP_W-1:0]    nerr
);
    import lbc_pkg::*;

    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        !bist_en |=> $stable(err_count)); // R1

    AST_COUNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !start |=> err_count >= $past(err_count)); // R6

    AST_PULSE_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (busy && nerr == '0 && !start) |=> pending == $past(pending) - 1'b1); // R4

    AST_VERDICT_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (err_count != '0) |-> fail); // R8

    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state == RUN_DONE && !start) |=> ($stable(err_count) && $stable(fail))); // R9

    AST_UNLOCKED_PAUSE: assert property (@(posedge clk) disable iff (rst)
        (!lock && !start) |=> $stable(err_count)); // R10

endmodule

bind link_bist_checker lbc_sva #(
    .CNT_W  (CNT_W),
    .PEND_W (PEND_W),
    .POP_W  (POP_W)
) u_sva (
    .clk       (clk),
    .rst       (rst),
    .bist_en   (bist_en),
    .lock      (lock),
    .start     (start_w),
    .state     (state_q),
    .err_count (err_count),
    .fail      (fail_w),
    .busy      (busy_w),
    .pending   (pending_w),
    .nerr      (nerr_w)
);

// File: tb/sim_link_bist_checker.sv
`timescale 1ns/100ps
module sim_link_bist_checker;

    logic        clk = 1'b0;
    logic        rst;
    logic        bist_en;
    logic        lock;
    logic [15:0] rx_word;
    logic        pass_o;
    logic [15:0] err_count;

    always #2.5 clk = ~clk;

    link_bist_checker u0 (
        .clk       (clk),
        .rst       (rst),
        .bist_en   (bist_en),
        .lock      (lock),
        .rx_word   (rx_word),
        .pass_o    (pass_o),
        .err_count (err_count)
    );

    int n_checks = 0;
    int n_errs   = 0;
    int pulses   = 0;
    bit finished = 1'b0;

    // pulse monitor: a pulse is high in the high phase, low in the low phase
    logic hi_s = 1'b1;
    always @(posedge clk) begin
        #1 hi_s = pass_o;
    end
    always @(negedge clk) begin
        #1 if (hi_s === 1'b1 && pass_o === 1'b0) pulses++;
    end

    // reference model state, built from the requirements
    logic [6:0]  hist;       // bit 0 newest sequence bit
    bit          m_need_seed = 1'b1;
    bit          m_prev_en   = 1'b0;
    bit          m_fail      = 1'b0;
    bit          m_done      = 1'b0;
    int          m_cnt       = 0;
    int          m_pend      = 0;
    logic [15:0] junk_q      = 16'hC35A;

    localparam int NFLIP = 10;
    localparam logic [15:0] FLIPS [0:NFLIP-1] = '{
        16'h0000, 16'h0001, 16'h0000, 16'h8001, 16'hFFFF,
        16'h0000, 16'h00F0, 16'h0300, 16'h0000, 16'h0001
    };

    function automatic logic [15:0] gen_word(input logic [6:0] h);
        logic [15:0] w;
        logic        b;
        for (int i = 0; i < 16; i++) begin
            b    = h[5] ^ h[6];
            w[i] = b;
            h    = {h[5:0], b};
        end
        return w;
    endfunction

    function automatic logic [6:0] hist_of(input logic [15:0] w);
        logic [6:0] h;
        for (int k = 0; k < 7; k++) h[k] = w[15-k];
        return h;
    endfunction

    function automatic logic exp_pass();
        if (m_pend > 0) return 1'b0;
        if (m_done)     return ~m_fail;
        return 1'b1;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one recovered clock cycle: optional low-phase check of pass_o for the
    // previous edge, then drive this cycle's word and update the model
    task automatic cyc(input logic en, input logic lk, input logic [15:0] mask,
                       input bit chk_pass, input string tag);
        logic [15:0] w;
        bit          start;
        int          n;
        @(negedge clk);
        #1;
        if (chk_pass) chk(tag, pass_o, exp_pass());
        start = en && !m_prev_en;
        if (en && lk && !m_need_seed && !start) begin
            w = gen_word(hist) ^ mask;
        end else begin
            junk_q = junk_q + 16'h3B91;
            w      = junk_q;
        end
        bist_en = en;
        lock    = lk;
        rx_word = w;
        @(posedge clk);
        #1;
        if (start) begin
            m_cnt = 0; m_fail = 1'b0; m_pend = 0; m_done = 1'b0; m_need_seed = 1'b1;
        end else if (m_pend > 0) begin
            m_pend--;
        end
        if (en) begin
            if (!lk) begin
                m_need_seed = 1'b1;
            end else if (m_need_seed) begin
                hist        = hist_of(w);
                m_need_seed = 1'b0;
            end else begin
                n      = $countones(w ^ gen_word(hist));
                hist   = hist_of(gen_word(hist));
                m_cnt  = (m_cnt + n > 65535) ? 65535 : m_cnt + n;
                m_pend += n;
                if (n != 0) m_fail = 1'b1;
            end
        end else if (m_prev_en) begin
            m_done = 1'b1;
        end
        m_prev_en = en;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; bist_en = 1'b0; lock = 1'b0; rx_word = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset pass", pass_o, 1);
        chk("R1 reset count", err_count, 0);

        // R1: enable low, words ignored
        repeat (4) cyc(1'b0, 1'b1, 16'h0, 1'b1, "R1 idle pass");
        chk("R1 idle count", err_count, 0);

        // table-driven run with chosen bit flips
        cyc(1'b1, 1'b1, 16'h0, 1'b0, "R2");
        chk("R2 seed not counted", err_count, 0);
        pulses = 0;
        for (int i = 0; i < NFLIP; i++) begin
            cyc(1'b1, 1'b1, FLIPS[i], i > 0, "R4 pulse level");
            chk("R5 count per word", err_count, m_cnt);
        end
        repeat (30) cyc(1'b1, 1'b1, 16'h0, 1'b1, "R3 pass during run");
        chk("R4 total pulses", pulses, 26);
        chk("R5 run total", err_count, 26);

        // end of run with errors
        cyc(1'b0, 1'b1, 16'h0, 1'b1, "R3 pass");
        repeat (3) cyc(1'b0, 1'b1, 16'h0, 1'b1, "R8 fail held");
        chk("R8 fail held level", pass_o, 0);
        repeat (5) cyc(1'b0, 1'b1, 16'h0, 1'b1, "R9 verdict held");
        chk("R9 count frozen", err_count, 26);
        chk("R4 no pulse after end", pulses, 26);

        // lock pause and re-seed
        cyc(1'b1, 1'b1, 16'h0, 1'b1, "R8");
        chk("R7 count cleared", err_count, 0);
        repeat (3) cyc(1'b1, 1'b1, 16'h0, 1'b1, "R3 pass clean");
        repeat (4) cyc(1'b1, 1'b0, 16'h0, 1'b1, "R10 pass unlocked");
        chk("R10 unlocked not counted", err_count, 0);
        cyc(1'b1, 1'b1, 16'h0, 1'b1, "R10 reseed");
        cyc(1'b1, 1'b1, 16'h0004, 1'b1, "R10");
        chk("R10 reseeded stream", err_count, 1);
        repeat (4) cyc(1'b1, 1'b1, 16'h0, 1'b1, "R4 drain");

        // clean run: held verdict high
        cyc(1'b0, 1'b1, 16'h0, 1'b1, "R8");
        cyc(1'b1, 1'b1, 16'h0, 1'b1, "R8");
        chk("R7 verdict cleared count", err_count, 0);
        repeat (6) cyc(1'b1, 1'b1, 16'h0, 1'b1, "R3 clean run");
        repeat (4) cyc(1'b0, 1'b1, 16'h0, 1'b1, "R8 pass held");
        chk("R8 pass held level", pass_o, 1);
        chk("R9 clean count", err_count, 0);

        // enable without lock, then lock arrives
        repeat (4) cyc(1'b1, 1'b0, 16'h0, 1'b1, "R10 no lock");
        chk("R10 no lock no count", err_count, 0);
        cyc(1'b1, 1'b1, 16'h0, 1'b1, "R2 late seed");
        cyc(1'b1, 1'b1, 16'h0300, 1'b1, "R2");
        chk("R2 late seed stream", err_count, 2);

        // saturation
        cyc(1'b0, 1'b1, 16'h0, 1'b0, "R6");
        cyc(1'b1, 1'b1, 16'h0, 1'b0, "R6");
        for (int i = 0; i < 4100; i++) cyc(1'b1, 1'b1, 16'hFFFF, 1'b0, "R6");
        chk("R6 saturated", err_count, 65535);
        cyc(1'b1, 1'b1, 16'hFFFF, 1'b0, "R6");
        chk("R6 stays saturated", err_count, 65535);
        cyc(1'b0, 1'b1, 16'h0, 1'b0, "R7");
        cyc(1'b1, 1'b1, 16'h0, 1'b0, "R7");
        chk("R7 clear after saturation", err_count, 0);
        cyc(1'b1, 1'b1, 16'h0, 1'b1, "R7 pending cleared");

        finish_run();
    end

endmodule